// File: doc/BRIEF.md
# Storage Device Status Poller

This block waits for a storage device to become ready. On a start pulse it captures a wait mask and a timeout counted in 10 ms ticks, then keeps asking a separate register access engine for reads of the device status byte. Each returned byte is judged. A set error flag stops the wait at once with an error result. This holds even while the device still reports busy. If the tick counter has run down to zero when a read returns, the wait ends with a timeout. A byte with busy clear that also satisfies the mask counts as a successful wait. After success the block makes one more read, this time of the alternate-status register, and only then reports ok.

The block does not drive device strobes or issue commands. It sits between a command sequencer, which starts it and consumes its 2-bit outcome, and the access engine, which performs each read on request. A free-running 100 Hz tick input paces the timeout.

Top module: `ata_stat_poll`

## Requirements
- R1: While reset is applied, and afterwards until a start is accepted, busy, done and rd_req are 0 and result is 00.
- R2: A start pulse while idle captures wait_mask and timeout_ticks, raises busy and issues status reads (rd_req=1, rd_alt=0) one after another until the wait ends. A start while busy is ignored, and so are changes to wait_mask and timeout_ticks while busy.
- R3: The status byte holds busy at bit 7, ready at bit 6, data-request at bit 3 and error at bit 0. A read counts as success when bit 7 is 0 and either the captured mask is zero or the mask and the byte share at least one set bit.
- R4: A status read with bit 0 set ends the wait with result 10. This applies whatever the busy bit and the remaining ticks are.
- R5: The tick counter is loaded at start and drops by one on each tick while it is above zero. It never goes below zero. A status read without error that completes while the counter is zero ends the wait with result 11, even if the device is ready. A tick in the same cycle as that completion takes effect afterwards.
- R6: After a successful status read, exactly one alternate-status read (rd_req=1, rd_alt=1) is made. Its completion ends the wait with result 01.
- R7: done is a one-cycle pulse in the cycle after the final read completes. result reads 00 while busy and keeps its outcome until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a wait (sampled only while idle) |
| wait_mask | input | 8 | Status bits of which any one ends the wait; zero waits for busy clear only |
| timeout_ticks | input | TW (16) | Timeout in 10 ms ticks |
| tick | input | 1 | One-cycle pulse every 10 ms |
| rd_req | output | 1 | Read request to the access engine, held until acknowledged |
| rd_alt | output | 1 | 1 selects the alternate-status register, 0 the status register |
| rd_ack | input | 1 | One-cycle completion of the requested read |
| rd_data | input | 8 | Byte read, valid with rd_ack |
| busy | output | 1 | A wait is in progress |
| done | output | 1 | One-cycle pulse when a wait ends |
| result | output | 2 | 00 busy, 01 ok, 10 error, 11 timeout |

## Verification
A start sampled at a clock edge shows on busy and rd_req right after that same edge. Each read completion sampled at an edge moves the request to the next read or to the alternate register right after that edge. When a completion is the last one, done and the final result appear right after that edge. A reference model steps on the rising edge from the same sampled inputs, and every output is compared with it at the falling edge, so each result is checked in exactly the cycle it is due. Separate end-of-wait checks look at the settled outcome, at whether the alternate read took place, and at holding of the result over idle cycles.

// File: rtl/ata_poll_pkg.sv
package ata_poll_pkg;
  localparam int SW       = 8;
  localparam int BIT_BUSY = 7;
  localparam int BIT_RDY  = 6;
  localparam int BIT_DREQ = 3;
  localparam int BIT_ERR  = 0;

  typedef enum logic [1:0] {
    RES_BUSY = 2'b00,
    RES_OK   = 2'b01,
    RES_ERR  = 2'b10,
    RES_TMO  = 2'b11
  } poll_res_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_STAT = 2'b01,
    ST_ALT  = 2'b10
  } poll_st_e;
endpackage

// File: rtl/poll_tick_timer.sv
module poll_tick_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  input  logic          tick,
  output logic          zero
);
  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (tick && (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

  // R5: count steps down by one per tick, never wraps below zero
  a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && zero) |=> zero);
endmodule

// File: rtl/poll_status_judge.sv
module poll_status_judge
  import ata_poll_pkg::*;
(
  input  logic [SW-1:0] stat,
  input  logic [SW-1:0] mask,
  output logic          is_err,
  output logic          is_ready
);
  logic mask_hit;

  always_comb begin
    is_err   = stat[BIT_ERR];
    mask_hit = (mask == '0) || ((stat & mask) != '0);
    is_ready = !stat[BIT_BUSY] && mask_hit;
  end
endmodule

// File: rtl/ata_stat_poll.sv
module ata_stat_poll
  import ata_poll_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    wait_mask,
  input  logic [TW-1:0] timeout_ticks,
  input  logic          tick,
  output logic          rd_req,
  output logic          rd_alt,
  input  logic          rd_ack,
  input  logic [7:0]    rd_data,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  poll_st_e      state_q, state_d;
  logic [SW-1:0] mask_q, mask_d;
  poll_res_e     res_q, res_d;
  logic          done_q, done_d;
  logic          tmr_load, tmr_zero;
  logic          st_err, st_ready;

  poll_tick_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_ni),
    .load     (tmr_load),
    .load_val (timeout_ticks),
    .tick     (tick),
    .zero     (tmr_zero)
  );

  poll_status_judge u_judge (
    .stat     (rd_data),
    .mask     (mask_q),
    .is_err   (st_err),
    .is_ready (st_ready)
  );

  always_comb begin
    state_d  = state_q;
    mask_d   = mask_q;
    res_d    = res_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d  = ST_STAT;
        mask_d   = wait_mask;
        res_d    = RES_BUSY;
        tmr_load = 1'b1;
      end
      ST_STAT: if (rd_ack) begin
        if (st_err) begin
          res_d = RES_ERR; done_d = 1'b1; state_d = ST_IDLE;
        end else if (tmr_zero) begin
          res_d = RES_TMO; done_d = 1'b1; state_d = ST_IDLE;
        end else if (st_ready) begin
          state_d = ST_ALT;
        end
      end
      ST_ALT: if (rd_ack) begin
        res_d = RES_OK; done_d = 1'b1; state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mask_q  <= '0;
      res_q   <= RES_BUSY;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mask_q  <= mask_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign rd_req = busy;
  assign rd_alt = (state_q == ST_ALT);
  assign done   = done_q;
  assign result = res_q;

  // R7: done lasts one cycle; outcome held while idle without start
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
  // R1/R2: no read requested while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);
  // R4: error flag on a status read ends the wait with error
  a_r4_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_alt && rd_ack && rd_data[BIT_ERR]) |=> (done && result == RES_ERR));
  // R6: ok only follows a completed alternate-status read
  a_r6_alt_first: assert property (@(posedge clk) disable iff (!rst_n)
    (done && result == RES_OK) |-> $past(rd_alt && rd_ack));
endmodule

// File: tb/sim_ata_stat_poll.sv
module sim_ata_stat_poll;
  localparam int CLK_PERIOD = 10;
  localparam int TW   = 16;
  localparam int TPER = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    wait_mask = 8'h00;
  logic [TW-1:0] timeout_ticks = '0;
  logic          tick = 1'b0;
  logic          rd_req, rd_alt, busy, done;
  logic          rd_ack = 1'b0;
  logic [7:0]    rd_data = 8'h00;
  logic [1:0]    result;

  always #(CLK_PERIOD/2) clk = ~clk;

  ata_stat_poll #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .wait_mask(wait_mask),
    .timeout_ticks(timeout_ticks), .tick(tick), .rd_req(rd_req), .rd_alt(rd_alt),
    .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy), .done(done), .result(result)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference model, stepped on the rising edge
  int m_st = 0;      // 0 idle, 1 status reads, 2 alternate read
  int m_cnt = 0;
  int m_mask = 0;
  int m_res = 0;
  bit m_done = 1'b0;

  always @(posedge clk) begin
    bit loaded;
    bit nd;
    loaded = 1'b0;
    nd = 1'b0;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_mask = 0; m_res = 0; m_done = 1'b0;
    end else begin
      if (m_st == 0) begin
        if (start) begin
          m_st = 1; m_mask = wait_mask; m_cnt = timeout_ticks; m_res = 0; loaded = 1'b1;
        end
      end else if (m_st == 1) begin
        if (rd_ack) begin
          if (rd_data[0]) begin m_res = 2; nd = 1'b1; m_st = 0; end
          else if (m_cnt == 0) begin m_res = 3; nd = 1'b1; m_st = 0; end
          else if (!rd_data[7] && (m_mask == 0 || (rd_data & m_mask[7:0]) != 0)) m_st = 2;
        end
      end else begin
        if (rd_ack) begin m_res = 1; nd = 1'b1; m_st = 0; end
      end
      if (!loaded && tick && m_cnt > 0) m_cnt = m_cnt - 1;
      m_done = nd;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(busy == (m_st != 0), "R2", "busy", busy, m_st != 0);
      chk(rd_req == (m_st != 0), "R2", "rd_req", rd_req, m_st != 0);
      chk(rd_alt == (m_st == 2), "R6", "rd_alt", rd_alt, m_st == 2);
      chk(done == m_done, "R7", "done", done, m_done);
      chk(int'(result) == m_res, "R7", "result", result, m_res);
    end
    if (cyc > 100000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // Access engine model and tick generator
  logic [7:0] cur_status = 8'h00;
  bit tick_en = 1'b0;
  bit saw_alt = 1'b0;
  int eng_wait = 1;
  int tcnt = 0;

  always @(negedge clk) begin
    rd_ack <= 1'b0;
    if (rd_req) begin
      if (eng_wait == 0) begin
        rd_ack <= 1'b1;
        rd_data <= rd_alt ? 8'h00 : cur_status;
        if (rd_alt) saw_alt = 1'b1;
        eng_wait = 1;
      end else eng_wait--;
    end else eng_wait = 1;
    tick <= 1'b0;
    if (tick_en) begin
      tcnt++;
      if (tcnt == TPER) begin tick <= 1'b1; tcnt = 0; end
    end else tcnt = 0;
  end

  task automatic kick(input logic [7:0] m, input int t);
    @(negedge clk);
    wait_mask = m; timeout_ticks = TW'(t); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(input string req, input int exp);
    int i;
    for (i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (done) break;
    end
    chk(done == 1'b1, req, "wait ended", done, 1);
    chk(int'(result) == exp, req, "outcome", result, exp);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && rd_req == 1'b0 && done == 1'b0, "R1", "idle in reset", busy, 0);
    chk(result == 2'b00, "R1", "result in reset", result, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(busy == 1'b0 && result == 2'b00, "R1", "idle after reset", busy, 0);

    // R3 R6: busy for a while, then ready
    cur_status = 8'h80; saw_alt = 1'b0;
    kick(8'h40, 100);
    repeat (10) @(negedge clk);
    cur_status = 8'h40;
    wait_end("R6", 1);
    chk(saw_alt == 1'b1, "R6", "alternate read made", saw_alt, 1);

    // R3: zero mask waits for busy clear only
    cur_status = 8'h10;
    kick(8'h00, 100);
    wait_end("R3", 1);

    // R3: busy bit blocks even with mask bit set
    cur_status = 8'hC8;
    kick(8'h08, 100);
    repeat (12) @(negedge clk);
    chk(busy == 1'b1, "R3", "still waiting on busy", busy, 1);
    cur_status = 8'h08;
    wait_end("R3", 1);

    // R5: mask never met, ticks run out
    cur_status = 8'h40; tick_en = 1'b1;
    kick(8'h08, 3);
    wait_end("R5", 3);
    tick_en = 1'b0;

    // R5: zero timeout fails even though ready
    cur_status = 8'h40;
    kick(8'h40, 0);
    wait_end("R5", 3);

    // R4: error while busy
    cur_status = 8'h81;
    kick(8'h40, 100);
    wait_end("R4", 2);

    // R4: error outranks timeout
    cur_status = 8'h01;
    kick(8'h40, 0);
    wait_end("R4", 2);

    // R2: restart while busy ignored
    cur_status = 8'h80;
    kick(8'h40, 50);
    repeat (4) @(negedge clk);
    kick(8'h00, 0);
    wait_mask = 8'h08;
    repeat (4) @(negedge clk);
    cur_status = 8'h40;
    wait_end("R2", 1);

    // R7: outcome held while idle
    repeat (6) @(negedge clk);
    chk(result == 2'b01 && busy == 1'b0, "R7", "held outcome", result, 1);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule